// File: doc/BRIEF.md
# Interval Energy Integrator

This block turns calibrated power samples into energy. Three channels (active, reactive and apparent power) each add one signed sample into a 42-bit internal sum on every pulse of the 4 kHz sample strobe. The active and reactive channels can be set to treat each sample in one of four ways. The apparent channel always uses the signed value.

An interval counter decides when the internal sums move into the 45-bit user energy registers. The interval is counted either in strobes or in voltage half line cycles. Half line cycles are found from sign changes of the voltage waveform sample. When the interval ends, each internal sum is either added to its user register or written over it. The internal sum then restarts from zero, and a sticky ready flag is raised. A host reads each user register as a high word and a low word. The power computation and the host bus sit outside this block.

Top module: `energy_accum_top`

## Requirements
- R1: After reset, all six energy words read zero and `rdy` is low.
- R2: On each cycle with `smp_stb` high, a channel adds its selected term into its 42-bit internal sum, wrapping modulo 2^42. With `smp_stb` low, no internal sum, energy word or counter changes.
- R3: The active and reactive mode codes work as follows. 0 adds the sample as is. 1 adds its magnitude. 2 adds the sample only when it is greater than zero, and adds 0 otherwise. 3 adds the sample (which is negative) only when it is below zero, and adds 0 otherwise.
- R4: The apparent channel always adds its sample as is, whatever the mode inputs hold.
- R5: With `cfg_half_cyc` low, every strobe is an event. The strobe that completes `cfg_intv`+1 events is a transfer. Its own sample is included in the value transferred, and the internal sum is zero afterwards. With `cfg_intv` = 0, every event is a transfer.
- R6: With `cfg_half_cyc` high, an event is a strobe whose voltage sample differs in sign from the voltage sample of the previous strobe. Zero counts as non-negative. The reference sign after reset is non-negative. Strobes that are not events still accumulate.
- R7: On a transfer, `cfg_add_user` = 1 adds the sign-extended internal value to the user register. `cfg_add_user` = 0 replaces the user register with that value.
- R8: Each energy word pair shows the 45-bit user register U as follows: the high word is U[44:13], the low word [31:19] is U[12:0], and the low word [18:0] is zero.
- R9: The user register wraps modulo 2^45 on overflow.
- R10: `rdy` goes high in the cycle after a transfer. It stays high until a cycle with `rdy_clr` high and no transfer, after which it reads low. When a transfer and `rdy_clr` fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe (4 kHz) |
| pwr_act | input | 32 | Signed active power sample |
| pwr_rea | input | 32 | Signed reactive power sample |
| pwr_app | input | 32 | Signed apparent power sample |
| volt_smp | input | 24 | Signed voltage waveform sample |
| cfg_act_mode | input | 2 | Active channel mode code |
| cfg_rea_mode | input | 2 | Reactive channel mode code |
| cfg_half_cyc | input | 1 | 1: count half line cycles, 0: count strobes |
| cfg_add_user | input | 1 | 1: add to user register, 0: load it |
| cfg_intv | input | 13 | Interval length minus one |
| rdy_clr | input | 1 | Write-one pulse that clears `rdy` |
| rdy | output | 1 | Interval-complete flag |
| act_hi | output | 32 | Active energy high word |
| act_lo | output | 32 | Active energy low word |
| rea_hi | output | 32 | Reactive energy high word |
| rea_lo | output | 32 | Reactive energy low word |
| app_hi | output | 32 | Apparent energy high word |
| app_lo | output | 32 | Apparent energy low word |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the end-of-interval transfer and the flag clear. The bench pulses `rdy_clr` on the very strobe that completes an interval and expects the flag to remain set. It then clears the flag with no strobe present and expects it to read low. The second pair is the last accumulation and the transfer, which share a strobe. The bench judges this by the fact that the transferred value already holds that strobe's sample, while the next interval starts from that sample excluded.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    ACC_SIGNED = 2'd0,
    ACC_ABS    = 2'd1,
    ACC_POS    = 2'd2,
    ACC_NEG    = 2'd3
  } acc_mode_e;

  localparam int NUM_CH = 3;
  localparam int CH_ACT = 0;
  localparam int CH_REA = 1;
  localparam int CH_APP = 2;
endpackage

// File: rtl/ea_zc_det.sv
module ea_zc_det #(
  parameter int VW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic signed [VW-1:0] volt,
  output logic                 zc
);
  logic prev_neg_q;
  logic cur_neg;

  function automatic logic is_neg(input logic signed [VW-1:0] v);
    return v < 0;
  endfunction

  assign cur_neg = is_neg(volt);
  assign zc      = stb && (cur_neg != prev_neg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_neg_q <= 1'b0;
    else if (stb) prev_neg_q <= cur_neg;
  end
endmodule

// File: rtl/ea_interval.sv
module ea_interval #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          zc,
  input  logic          half_mode,
  input  logic [TW-1:0] intv,
  output logic          evt,
  output logic          xfer
);
  logic [TW-1:0] cnt_q;

  assign evt  = half_mode ? zc : stb;
  assign xfer = evt && (cnt_q >= intv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (xfer) cnt_q <= '0;
    else if (evt)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ea_channel.sv
module ea_channel
  import ea_pkg::*;
#(
  parameter int PW = 32,
  parameter int AW = 42,
  parameter int UW = 45
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic                 xfer,
  input  logic                 add_user,
  input  acc_mode_e            mode,
  input  logic signed [PW-1:0] pwr,
  output logic        [AW-1:0] acc_q,
  output logic        [UW-1:0] user_q
);
  localparam int EXT_A = AW - PW;
  localparam int EXT_U = UW - AW;

  logic [AW-1:0] term;
  logic [AW-1:0] acc_next;
  logic [UW-1:0] acc_wide;

  function automatic logic [AW-1:0] pick_term(input logic signed [PW-1:0] p,
                                               input acc_mode_e m);
    logic [AW-1:0] w;
    w = {{EXT_A{p[PW-1]}}, p};
    case (m)
      ACC_ABS: return p[PW-1] ? (~w + 1'b1) : w;
      ACC_POS: return (p > 0) ? w : '0;
      ACC_NEG: return p[PW-1] ? w : '0;
      default: return w;
    endcase
  endfunction

  function automatic logic [UW-1:0] widen(input logic [AW-1:0] a);
    return {{EXT_U{a[AW-1]}}, a};
  endfunction

  assign term     = pick_term(pwr, mode);
  assign acc_next = acc_q + term;
  assign acc_wide = widen(acc_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      user_q <= '0;
    end else if (stb) begin
      if (xfer) begin
        acc_q  <= '0;
        user_q <= add_user ? (user_q + acc_wide) : acc_wide;
      end else begin
        acc_q <= acc_next;
      end
    end
  end
endmodule

// File: rtl/energy_accum_top.sv
module energy_accum_top
  import ea_pkg::*;
#(
  parameter int PW = 32,
  parameter int AW = 42,
  parameter int UW = 45,
  parameter int TW = 13,
  parameter int VW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [PW-1:0] pwr_act,
  input  logic signed [PW-1:0] pwr_rea,
  input  logic signed [PW-1:0] pwr_app,
  input  logic signed [VW-1:0] volt_smp,
  input  logic [1:0]           cfg_act_mode,
  input  logic [1:0]           cfg_rea_mode,
  input  logic                 cfg_half_cyc,
  input  logic                 cfg_add_user,
  input  logic [TW-1:0]        cfg_intv,
  input  logic                 rdy_clr,
  output logic                 rdy,
  output logic [31:0]          act_hi,
  output logic [31:0]          act_lo,
  output logic [31:0]          rea_hi,
  output logic [31:0]          rea_lo,
  output logic [31:0]          app_hi,
  output logic [31:0]          app_lo
);
  localparam int WORD = 32;
  localparam int LOB  = UW - WORD;
  localparam int PAD  = WORD - LOB;

  logic                 zc;
  logic                 evt;
  logic                 xfer;
  logic signed [PW-1:0] pwr_arr  [NUM_CH];
  acc_mode_e            mode_arr [NUM_CH];
  logic [AW-1:0]        acc_q    [NUM_CH];
  logic [UW-1:0]        user_q   [NUM_CH];
  logic [WORD-1:0]      hi_w     [NUM_CH];
  logic [WORD-1:0]      lo_w     [NUM_CH];

  assign pwr_arr[CH_ACT]  = pwr_act;
  assign pwr_arr[CH_REA]  = pwr_rea;
  assign pwr_arr[CH_APP]  = pwr_app;
  assign mode_arr[CH_ACT] = acc_mode_e'(cfg_act_mode);
  assign mode_arr[CH_REA] = acc_mode_e'(cfg_rea_mode);
  assign mode_arr[CH_APP] = ACC_SIGNED;

  ea_zc_det #(.VW(VW)) u_zc (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .volt(volt_smp), .zc(zc)
  );

  ea_interval #(.TW(TW)) u_intv (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .zc(zc),
    .half_mode(cfg_half_cyc), .intv(cfg_intv), .evt(evt), .xfer(xfer)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ea_channel #(.PW(PW), .AW(AW), .UW(UW)) u_ch (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .xfer(xfer),
      .add_user(cfg_add_user), .mode(mode_arr[c]), .pwr(pwr_arr[c]),
      .acc_q(acc_q[c]), .user_q(user_q[c])
    );
    assign hi_w[c] = user_q[c][UW-1:LOB];
    assign lo_w[c] = {user_q[c][LOB-1:0], {PAD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdy <= 1'b0;
    else if (xfer)    rdy <= 1'b1;
    else if (rdy_clr) rdy <= 1'b0;
  end

  assign act_hi = hi_w[CH_ACT];
  assign act_lo = lo_w[CH_ACT];
  assign rea_hi = hi_w[CH_REA];
  assign rea_lo = lo_w[CH_REA];
  assign app_hi = hi_w[CH_APP];
  assign app_lo = lo_w[CH_APP];
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int AW = 42
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic          half,
  input logic          evt,
  input logic          xfer,
  input logic          rdy,
  input logic          rdy_clr,
  input logic [AW-1:0] acc0,
  input logic [31:0]   act_hi,
  input logic [31:0]   act_lo
);
  // R10
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> rdy);
  // R10
  rdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_clr && !xfer) |=> !rdy);
  // R10
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && !xfer) |=> !rdy);
  // R5
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (acc0 == '0));
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(acc0) && $stable(act_hi) && $stable(act_lo)));
  // R6
  half_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half && evt) |-> smp_stb);
endmodule

bind energy_accum_top ea_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .half(cfg_half_cyc),
  .evt(evt), .xfer(xfer), .rdy(rdy), .rdy_clr(rdy_clr),
  .acc0(acc_q[0]), .act_hi(act_hi), .act_lo(act_lo)
);

// File: tb/test_energy_accum_top.sv
module test_energy_accum_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [31:0] pwr_act = '0, pwr_rea = '0, pwr_app = '0;
  logic signed [23:0] volt_smp = '0;
  logic [1:0] cfg_act_mode = 2'd0, cfg_rea_mode = 2'd0;
  logic cfg_half_cyc = 1'b0, cfg_add_user = 1'b1;
  logic [12:0] cfg_intv = 13'd3;
  logic rdy_clr = 1'b0;
  logic rdy;
  logic [31:0] act_hi, act_lo, rea_hi, rea_lo, app_hi, app_lo;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic signed [41:0] m_acc [3];
  logic signed [44:0] m_usr [3];
  int m_cnt;
  bit m_prev;
  bit m_rdy;

  // columns: active, reactive, apparent, voltage
  localparam logic [31:0] VEC [12][4] = '{
    '{32'd1000,      32'd200,        32'd5000,   32'd100},
    '{-32'd300,      -32'd50,        32'd7000,   -32'd20},
    '{32'd0,         32'd0,          -32'd10,    -32'd1},
    '{32'h7FFFFFFF,  32'h80000000,   32'd12,     32'd0},
    '{32'h80000000,  32'h7FFFFFFF,   -32'd400,   32'd55},
    '{32'd77,        -32'd77,        32'd1,      -32'd9},
    '{-32'd1,        32'd1,          32'd0,      32'd9},
    '{32'd123456,    -32'd654321,    32'd999,    32'd3},
    '{-32'd8192,     32'd8192,       -32'd8192,  -32'd3},
    '{32'd5,         32'd6,          32'd7,      -32'd4},
    '{32'h40000000,  -32'h40000000,  32'd8,      32'd4},
    '{-32'd2,        -32'd3,         -32'd4,     32'd1}
  };

  energy_accum_top i_energy_accum_top (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .pwr_act(pwr_act), .pwr_rea(pwr_rea), .pwr_app(pwr_app),
    .volt_smp(volt_smp), .cfg_act_mode(cfg_act_mode), .cfg_rea_mode(cfg_rea_mode),
    .cfg_half_cyc(cfg_half_cyc), .cfg_add_user(cfg_add_user), .cfg_intv(cfg_intv),
    .rdy_clr(rdy_clr), .rdy(rdy),
    .act_hi(act_hi), .act_lo(act_lo), .rea_hi(rea_hi), .rea_lo(rea_lo),
    .app_hi(app_hi), .app_lo(app_lo)
  );

  always #2 clk = ~clk;

  function automatic logic signed [41:0] bterm(input logic signed [31:0] p, input int m);
    logic signed [41:0] w;
    w = p;
    if (m == 1) return (p < 0) ? -w : w;
    if (m == 2) return (p > 0) ? w : 42'sd0;
    if (m == 3) return (p < 0) ? w : 42'sd0;
    return w;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = '0;
      m_usr[c] = '0;
    end
    m_cnt = 0;
    m_prev = 1'b0;
    m_rdy = 1'b0;
  endtask

  task automatic compare(input string req);
    logic [31:0] e [7];
    logic [31:0] a [7];
    bit bad;
    e[0] = m_usr[0][44:13]; e[1] = {m_usr[0][12:0], 19'd0};
    e[2] = m_usr[1][44:13]; e[3] = {m_usr[1][12:0], 19'd0};
    e[4] = m_usr[2][44:13]; e[5] = {m_usr[2][12:0], 19'd0};
    e[6] = {31'd0, m_rdy};
    a[0] = act_hi; a[1] = act_lo; a[2] = rea_hi; a[3] = rea_lo;
    a[4] = app_hi; a[5] = app_lo; a[6] = {31'd0, rdy};
    bad = 1'b0;
    for (int k = 0; k < 7; k++) if (a[k] !== e[k]) bad = 1'b1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: got act %h_%h rea %h_%h app %h_%h rdy %0d, expected act %h_%h rea %h_%h app %h_%h rdy %0d",
               req, a[0], a[1], a[2], a[3], a[4], a[5], a[6][0],
               e[0], e[1], e[2], e[3], e[4], e[5], e[6][0]);
    end
  endtask

  task automatic step(input logic [31:0] pa, input logic [31:0] pr, input logic [31:0] pp,
                      input logic [31:0] v, input bit stb, input bit clr, input string req);
    bit ev, xf, neg;
    logic signed [41:0] s;
    logic signed [44:0] ext;
    int md;
    @(negedge clk);
    pwr_act = pa; pwr_rea = pr; pwr_app = pp; volt_smp = v[23:0];
    smp_stb = stb; rdy_clr = clr;
    @(posedge clk);
    #1;
    xf = 1'b0;
    if (stb) begin
      neg = $signed(v[23:0]) < 0;
      ev = cfg_half_cyc ? (neg != m_prev) : 1'b1;
      m_prev = neg;
      xf = ev && (m_cnt >= int'(cfg_intv));
      for (int c = 0; c < 3; c++) begin
        md = (c == 0) ? int'(cfg_act_mode) : (c == 1) ? int'(cfg_rea_mode) : 0;
        s = m_acc[c] + bterm((c == 0) ? pa : (c == 1) ? pr : pp, md);
        if (xf) begin
          ext = s;
          m_usr[c] = cfg_add_user ? (m_usr[c] + ext) : ext;
          m_acc[c] = '0;
        end else begin
          m_acc[c] = s;
        end
      end
      if (xf) m_cnt = 0;
      else if (ev) m_cnt++;
    end
    if (xf) m_rdy = 1'b1;
    else if (clr) m_rdy = 1'b0;
    smp_stb = 1'b0;
    rdy_clr = 1'b0;
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got running, expected finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1 reset state");

    // Table pass 1: strobe interval of 4, add to user, abs / positive-only
    cfg_intv = 13'd3; cfg_add_user = 1'b1; cfg_act_mode = 2'd1; cfg_rea_mode = 2'd2;
    for (int i = 0; i < 12; i++)
      step(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b1, 1'b0, "R2 R3 R4 R5 R7 R8 pass1");
    // no strobe: nothing moves (R2)
    step(32'd999, 32'd999, 32'd999, 32'd0, 1'b0, 1'b0, "R2 idle");

    // Table pass 2: interval of 3, load mode, negative-only / signed
    do_reset();
    cfg_intv = 13'd2; cfg_add_user = 1'b0; cfg_act_mode = 2'd3; cfg_rea_mode = 2'd0;
    for (int i = 0; i < 12; i++)
      step(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b1, 1'b0, "R3 R4 R7 pass2");

    // Half line cycle interval (R6)
    do_reset();
    cfg_half_cyc = 1'b1; cfg_intv = 13'd1; cfg_add_user = 1'b1; cfg_act_mode = 2'd0;
    for (int i = 0; i < 12; i++)
      step(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b1, 1'b0, "R6 half cycles");
    cfg_half_cyc = 1'b0;

    // Ready flag: clear alone, then clear together with a transfer (R10)
    do_reset();
    cfg_intv = 13'd1;
    step(32'd10, 32'd20, 32'd30, 32'd1, 1'b1, 1'b0, "R10 before transfer");
    step(32'd10, 32'd20, 32'd30, 32'd1, 1'b1, 1'b0, "R10 set");
    step(32'd0, 32'd0, 32'd0, 32'd1, 1'b0, 1'b0, "R10 hold");
    step(32'd0, 32'd0, 32'd0, 32'd1, 1'b0, 1'b1, "R10 clear");
    step(32'd5, 32'd5, 32'd5, 32'd1, 1'b1, 1'b0, "R10 mid interval");
    step(32'd5, 32'd5, 32'd5, 32'd1, 1'b1, 1'b1, "R10 set wins over clear");

    // Interval of one strobe (R5)
    do_reset();
    cfg_intv = 13'd0; cfg_add_user = 1'b1;
    for (int i = 0; i < 6; i++)
      step(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b1, 1'b0, "R5 single-event interval");

    // User register wrap (R9)
    do_reset();
    cfg_intv = 13'd1023; cfg_add_user = 1'b1; cfg_act_mode = 2'd0; cfg_rea_mode = 2'd1;
    for (int i = 0; i < 9 * 1024; i++)
      step(32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'd1, 1'b1, 1'b0, "R9 user wrap");
    if (act_hi[31] !== 1'b1) begin
      fails++;
      $display("FAIL R9: got act_hi sign %0d, expected 1", act_hi[31]);
    end
    checks++;

    finish_run();
  end
endmodule